// File: doc/BRIEF.md
# Two-Wide In-Order Dispatch Resource Allocator

This block sits at the dispatch stage of an out-of-order core. Each cycle it looks at the two oldest instructions waiting in the dispatch buffer (slot 0 is older than slot 1). It decides which of them may move into the execution core. An instruction leaves only when three things can be handed to it together: a physical rename register, an entry in the station group that matches its type (adder or multiply/divide), and a reorder buffer entry. If any one of the three is missing, the instruction waits. A younger instruction never passes an older one that is waiting.

Rename registers and station entries are kept as free bitmaps. The lowest-numbered free entry is always the one handed out. The reorder buffer is a circular queue: allocation hands out consecutive entries from the tail, and retirement shrinks the occupancy. Reclaim inputs from completion and retirement return entries to the pools. The dispatch decision and the allocated identifiers are combinational outputs. Every pool update is registered, so a grant takes effect at the next clock edge.

Top module: `dispatch_alloc`

## Requirements
- R1: While `rst_n` is low, neither slot dispatches. After reset every pool is full and the reorder buffer is empty, so the first dispatched instruction receives rename register 0, station 0 of its group and reorder buffer entry 0.
- R2: Slot 1 dispatches only in a cycle in which slot 0 dispatches.
- R3: Slot 0 dispatches (`go0`=1) exactly when it is valid and, at the same time, a rename register, a station entry of its group and a reorder buffer entry are all free.
- R4: Slot 1 needs a second free entry in every pool it shares with slot 0. These are always the rename pool and the reorder buffer, and also the station group when both slots have the same type. When only one such entry is free, only slot 0 dispatches.
- R5: `slotN_mul`=1 routes the instruction to the multiply/divide stations and `slotN_mul`=0 routes it to the adder stations. The reported station index counts within that group.
- R6: From each free bitmap the lowest-numbered free entry is granted. When both slots draw from the same pool, slot 0 takes the lowest free entry and slot 1 takes the next lowest.
- R7: Slot 0 receives the reorder buffer tail entry and slot 1 receives tail+1 modulo `ROB_DEPTH`. The tail advances by the number of instructions dispatched and wraps at `ROB_DEPTH`.
- R8: An entry reclaimed in a cycle (rename register, station entry, or reorder buffer entries through `retire_cnt`) cannot be granted in that same cycle. It can be granted from the next cycle on.
- R9: At most `ROB_DEPTH` entries are outstanding. While the buffer is full nothing dispatches. After k entries are retired, at most k instructions dispatch in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot0_valid | input | 1 | Older buffered instruction present |
| slot0_mul | input | 1 | Older instruction type: 1 multiply/divide, 0 adder |
| slot1_valid | input | 1 | Younger buffered instruction present |
| slot1_mul | input | 1 | Younger instruction type: 1 multiply/divide, 0 adder |
| preg_rel_valid | input | 1 | Return one rename register |
| preg_rel_idx | input | PIW | Rename register being returned |
| add_rel_valid | input | 1 | Return one adder station entry |
| add_rel_idx | input | RSW | Adder station entry being returned |
| mul_rel_valid | input | 1 | Return one multiply/divide station entry |
| mul_rel_idx | input | RSW | Multiply/divide station entry being returned |
| retire_cnt | input | 2 | Reorder buffer entries retired this cycle (0 to 2) |
| go0 | output | 1 | Slot 0 dispatches this cycle |
| go1 | output | 1 | Slot 1 dispatches this cycle |
| go0_preg | output | PIW | Rename register granted to slot 0 |
| go1_preg | output | PIW | Rename register granted to slot 1 |
| go0_rs | output | RSW | Station index granted to slot 0 within its group |
| go1_rs | output | RSW | Station index granted to slot 1 within its group |
| go0_rob | output | RBW | Reorder buffer entry granted to slot 0 |
| go1_rob | output | RBW | Reorder buffer entry granted to slot 1 |

## Verification
The hardest case to reach from the ports is a full reorder buffer while rename registers and station entries are still free. The bench reaches it by giving the rename pool more entries than the reorder buffer and by returning station entries every cycle while it dispatches add/multiply pairs with no retirement. Once the buffer is full, retiring a single entry shows both the one-cycle delay of a reclaim and the partial admission of only slot 0. A long pseudo-random run then sweeps every mix of slot validity, type, reclaim and retire count against an arithmetic model of the bitmaps and the circular buffer.

// File: rtl/dalloc_pkg.sv
package dalloc_pkg;

   typedef enum logic {
      GRP_ADD = 1'b0,
      GRP_MUL = 1'b1
   } grp_e;

   // index width for a pool of n entries, never below one bit
   function automatic int idx_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/free_pool.sv
module free_pool #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    take_n,
   input  logic          rel_v,
   input  logic [IW-1:0] rel_idx,
   output logic [IW-1:0] first_idx,
   output logic [IW-1:0] second_idx,
   output logic          has1,
   output logic          has2
);
   localparam int NP = 1 << IW;
   localparam logic [NP-1:0] MASK = NP'((1 << N) - 1);

   generate
      if (N < 1 || NP < N) begin : g_bad_cfg
         initial $fatal(1, "free_pool: index width too small for N");
      end
   endgenerate

   logic [NP-1:0] free_q, free_d;

   always_comb begin
      first_idx  = '0;
      second_idx = '0;
      has1       = 1'b0;
      has2       = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (free_q[i]) begin
            if (!has1) begin
               first_idx = IW'(i);
               has1      = 1'b1;
            end else if (!has2) begin
               second_idx = IW'(i);
               has2       = 1'b1;
            end
         end
      end
   end

   always_comb begin
      free_d = free_q;
      if (take_n != 2'd0) free_d[first_idx]  = 1'b0;
      if (take_n == 2'd2) free_d[second_idx] = 1'b0;
      if (rel_v)          free_d[rel_idx]    = 1'b1;
      free_d = free_d & MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) free_q <= MASK;
      else        free_q <= free_d;
   end

endmodule

// File: rtl/rob_ring.sv
module rob_ring #(
   parameter int DEPTH = 8,
   parameter int IW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    alloc_n,
   input  logic [1:0]    retire_n,
   output logic [IW-1:0] id0,
   output logic [IW-1:0] id1,
   output logic          has1,
   output logic          has2
);
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = (DEPTH == (1 << IW));

   generate
      if (DEPTH < 2 || (1 << IW) < DEPTH) begin : g_bad_cfg
         initial $fatal(1, "rob_ring: bad depth or index width");
      end
   endgenerate

   logic [IW-1:0] tail_q, id2;
   logic [CW-1:0] cnt_q;

   assign id0 = tail_q;

   generate
      if (POW2) begin : g_wrap_free
         assign id1 = tail_q + IW'(1);
         assign id2 = tail_q + IW'(2);
      end else begin : g_wrap_cmp
         assign id1 = (tail_q == IW'(DEPTH - 1)) ? '0 : tail_q + IW'(1);
         assign id2 = (id1    == IW'(DEPTH - 1)) ? '0 : id1 + IW'(1);
      end
   endgenerate

   assign has1 = cnt_q <  CW'(DEPTH);
   assign has2 = cnt_q <= CW'(DEPTH - 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(alloc_n) - CW'(retire_n);
         case (alloc_n)
            2'd1:    tail_q <= id1;
            2'd2:    tail_q <= id2;
            default: tail_q <= tail_q;
         endcase
      end
   end

endmodule

// File: rtl/dispatch_alloc.sv
module dispatch_alloc
   import dalloc_pkg::*;
#(
   parameter int PREG_N    = 8,
   parameter int ADD_RS    = 3,
   parameter int MUL_RS    = 2,
   parameter int ROB_DEPTH = 8,
   localparam int PIW = idx_w(PREG_N),
   localparam int RSW = idx_w((ADD_RS > MUL_RS) ? ADD_RS : MUL_RS),
   localparam int RBW = idx_w(ROB_DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           slot0_valid,
   input  logic           slot0_mul,
   input  logic           slot1_valid,
   input  logic           slot1_mul,
   input  logic           preg_rel_valid,
   input  logic [PIW-1:0] preg_rel_idx,
   input  logic           add_rel_valid,
   input  logic [RSW-1:0] add_rel_idx,
   input  logic           mul_rel_valid,
   input  logic [RSW-1:0] mul_rel_idx,
   input  logic [1:0]     retire_cnt,
   output logic           go0,
   output logic           go1,
   output logic [PIW-1:0] go0_preg,
   output logic [PIW-1:0] go1_preg,
   output logic [RSW-1:0] go0_rs,
   output logic [RSW-1:0] go1_rs,
   output logic [RBW-1:0] go0_rob,
   output logic [RBW-1:0] go1_rob
);

   generate
      if (PREG_N < 2 || ADD_RS < 1 || MUL_RS < 1 || ROB_DEPTH < 2) begin : g_bad_cfg
         initial $fatal(1, "dispatch_alloc: pool sizes out of range");
      end
   endgenerate

   grp_e g0, g1;
   assign g0 = grp_e'(slot0_mul);
   assign g1 = grp_e'(slot1_mul);

   logic [1:0] preg_take, add_take, mul_take, rob_take;
   logic [PIW-1:0] preg_a, preg_b;
   logic [RSW-1:0] add_a, add_b, mul_a, mul_b;
   logic preg_h1, preg_h2, add_h1, add_h2, mul_h1, mul_h2, rob_h1, rob_h2;
   logic rs_ok0, rs_ok1;

   free_pool #(.N(PREG_N), .IW(PIW)) u_preg (
      .clk(clk), .rst_n(rst_n), .take_n(preg_take),
      .rel_v(preg_rel_valid), .rel_idx(preg_rel_idx),
      .first_idx(preg_a), .second_idx(preg_b), .has1(preg_h1), .has2(preg_h2));

   free_pool #(.N(ADD_RS), .IW(RSW)) u_add (
      .clk(clk), .rst_n(rst_n), .take_n(add_take),
      .rel_v(add_rel_valid), .rel_idx(add_rel_idx),
      .first_idx(add_a), .second_idx(add_b), .has1(add_h1), .has2(add_h2));

   free_pool #(.N(MUL_RS), .IW(RSW)) u_mul (
      .clk(clk), .rst_n(rst_n), .take_n(mul_take),
      .rel_v(mul_rel_valid), .rel_idx(mul_rel_idx),
      .first_idx(mul_a), .second_idx(mul_b), .has1(mul_h1), .has2(mul_h2));

   rob_ring #(.DEPTH(ROB_DEPTH), .IW(RBW)) u_rob (
      .clk(clk), .rst_n(rst_n), .alloc_n(rob_take), .retire_n(retire_cnt),
      .id0(go0_rob), .id1(go1_rob), .has1(rob_h1), .has2(rob_h2));

   // station availability and routing per slot
   always_comb begin
      rs_ok0 = (g0 == GRP_MUL) ? mul_h1 : add_h1;
      go0_rs = (g0 == GRP_MUL) ? mul_a  : add_a;
      if (g1 == g0) begin
         rs_ok1 = (g1 == GRP_MUL) ? mul_h2 : add_h2;
         go1_rs = (g1 == GRP_MUL) ? mul_b  : add_b;
      end else begin
         rs_ok1 = (g1 == GRP_MUL) ? mul_h1 : add_h1;
         go1_rs = (g1 == GRP_MUL) ? mul_a  : add_a;
      end
   end

   // all-or-nothing grant, slot 1 chained behind slot 0
   assign go0 = rst_n & slot0_valid & preg_h1 & rob_h1 & rs_ok0;
   assign go1 = go0 & slot1_valid & preg_h2 & rob_h2 & rs_ok1;

   assign go0_preg = preg_a;
   assign go1_preg = preg_b;

   assign preg_take = {1'b0, go0} + {1'b0, go1};
   assign rob_take  = preg_take;
   assign add_take  = {1'b0, go0 & (g0 == GRP_ADD)} + {1'b0, go1 & (g1 == GRP_ADD)};
   assign mul_take  = {1'b0, go0 & (g0 == GRP_MUL)} + {1'b0, go1 & (g1 == GRP_MUL)};

endmodule

// File: rtl/dispatch_alloc_chk.sv
module dispatch_alloc_chk #(
   parameter int ROB_DEPTH = 8,
   parameter int PIW = 3,
   parameter int RSW = 2,
   parameter int RBW = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           slot0_valid,
   input logic           slot0_mul,
   input logic           slot1_valid,
   input logic           slot1_mul,
   input logic           go0,
   input logic           go1,
   input logic [PIW-1:0] go0_preg,
   input logic [PIW-1:0] go1_preg,
   input logic [RSW-1:0] go0_rs,
   input logic [RSW-1:0] go1_rs,
   input logic [RBW-1:0] go0_rob,
   input logic [RBW-1:0] go1_rob
);

   function automatic logic [RBW-1:0] rob_step(input logic [RBW-1:0] x, input int n);
      return RBW'((int'(x) + n) % ROB_DEPTH);
   endfunction

   // R2: younger slot never goes alone
   a_r2_in_order: assert property (@(posedge clk) disable iff (!rst_n)
      go1 |-> go0);

   // R3: a grant needs a valid instruction
   a_r3_valid_needed: assert property (@(posedge clk) disable iff (!rst_n)
      (go0 |-> slot0_valid) and (go1 |-> slot1_valid));

   // R6: two grants from the same pool are distinct
   a_r6_preg_distinct: assert property (@(posedge clk) disable iff (!rst_n)
      go1 |-> (go1_preg != go0_preg));

   a_r6_rs_distinct: assert property (@(posedge clk) disable iff (!rst_n)
      (go1 && (slot0_mul == slot1_mul)) |-> (go1_rs != go0_rs));

   // R7: consecutive entries, tail moves by grant count
   a_r7_rob_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
      go1 |-> (go1_rob == rob_step(go0_rob, 1)));

   a_r7_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (go0_rob == rob_step($past(go0_rob),
                                    int'($past(go0)) + int'($past(go1)))));

endmodule

bind dispatch_alloc dispatch_alloc_chk #(
   .ROB_DEPTH(ROB_DEPTH), .PIW(PIW), .RSW(RSW), .RBW(RBW)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .slot0_valid(slot0_valid), .slot0_mul(slot0_mul),
   .slot1_valid(slot1_valid), .slot1_mul(slot1_mul),
   .go0(go0), .go1(go1),
   .go0_preg(go0_preg), .go1_preg(go1_preg),
   .go0_rs(go0_rs), .go1_rs(go1_rs),
   .go0_rob(go0_rob), .go1_rob(go1_rob)
);

// File: tb/test_dispatch_alloc.sv
`timescale 1ns/1ps
module test_dispatch_alloc;
   localparam int NP = 12, NA = 3, NM = 2, ND = 8;
   localparam int PIW = 4, RSW = 2, RBW = 3;

   logic clk = 1'b0;
   logic rst_n;
   logic slot0_valid, slot0_mul, slot1_valid, slot1_mul;
   logic preg_rel_valid, add_rel_valid, mul_rel_valid;
   logic [PIW-1:0] preg_rel_idx;
   logic [RSW-1:0] add_rel_idx, mul_rel_idx;
   logic [1:0] retire_cnt;
   logic go0, go1;
   logic [PIW-1:0] go0_preg, go1_preg;
   logic [RSW-1:0] go0_rs, go1_rs;
   logic [RBW-1:0] go0_rob, go1_rob;

   always #4 clk = ~clk;

   dispatch_alloc #(.PREG_N(NP), .ADD_RS(NA), .MUL_RS(NM), .ROB_DEPTH(ND)) i_dispatch_alloc (
      .clk(clk), .rst_n(rst_n),
      .slot0_valid(slot0_valid), .slot0_mul(slot0_mul),
      .slot1_valid(slot1_valid), .slot1_mul(slot1_mul),
      .preg_rel_valid(preg_rel_valid), .preg_rel_idx(preg_rel_idx),
      .add_rel_valid(add_rel_valid), .add_rel_idx(add_rel_idx),
      .mul_rel_valid(mul_rel_valid), .mul_rel_idx(mul_rel_idx),
      .retire_cnt(retire_cnt),
      .go0(go0), .go1(go1), .go0_preg(go0_preg), .go1_preg(go1_preg),
      .go0_rs(go0_rs), .go1_rs(go1_rs), .go0_rob(go0_rob), .go1_rob(go1_rob));

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;
   bit [31:0] lfsr = 32'h1234_5679;

   // arithmetic model: free bitmaps, occupancy, tail
   int pf, af, mf, rcnt, rtail;
   // last observed outputs
   int o_g0, o_g1, o_p0, o_rs0, o_rs1, o_rob0;

   task automatic chk(input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   function automatic int low(input int bits, input int n, input int skip);
      for (int i = 0; i < n; i++) if (bits[i] && i != skip) return i;
      return -1;
   endfunction

   task automatic model_reset();
      pf = (1 << NP) - 1; af = (1 << NA) - 1; mf = (1 << NM) - 1;
      rcnt = 0; rtail = 0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      slot0_valid = 1'b1; slot0_mul = 1'b0; slot1_valid = 1'b1; slot1_mul = 1'b1;
      preg_rel_valid = 1'b0; add_rel_valid = 1'b0; mul_rel_valid = 1'b0;
      preg_rel_idx = '0; add_rel_idx = '0; mul_rel_idx = '0; retire_cnt = '0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 no slot0 grant in reset", int'(go0), 0);
      chk("R1 no slot1 grant in reset", int'(go1), 0);
      rst_n = 1'b1;
      slot0_valid = 1'b0; slot1_valid = 1'b0;
      model_reset();
      @(negedge clk);
   endtask

   task automatic cyc(input bit v0, input bit m0, input bit v1, input bit m1,
                      input bit pr, input bit ar, input bit mr, input int rt);
      int pri, ari, mri, rtc, p0, p1, a0, a1, q0, q1, s0, s1, n;
      bit e0, e1;
      pri = pr ? low(~pf & ((1 << NP) - 1), NP, -1) : -1;
      ari = ar ? low(~af & ((1 << NA) - 1), NA, -1) : -1;
      mri = mr ? low(~mf & ((1 << NM) - 1), NM, -1) : -1;
      rtc = (rt > 2) ? 2 : rt;
      if (rtc > rcnt) rtc = rcnt;
      slot0_valid = v0; slot0_mul = m0; slot1_valid = v1; slot1_mul = m1;
      preg_rel_valid = (pri >= 0); preg_rel_idx = PIW'((pri >= 0) ? pri : 0);
      add_rel_valid  = (ari >= 0); add_rel_idx  = RSW'((ari >= 0) ? ari : 0);
      mul_rel_valid  = (mri >= 0); mul_rel_idx  = RSW'((mri >= 0) ? mri : 0);
      retire_cnt = 2'(rtc);
      #1;
      p0 = low(pf, NP, -1); p1 = low(pf, NP, p0);
      a0 = low(af, NA, -1); a1 = low(af, NA, a0);
      q0 = low(mf, NM, -1); q1 = low(mf, NM, q0);
      s0 = m0 ? q0 : a0;
      if (m1 == m0) s1 = m1 ? q1 : a1;
      else          s1 = m1 ? q0 : a0;
      e0 = v0 && p0 >= 0 && rcnt < ND && s0 >= 0;
      e1 = e0 && v1 && p1 >= 0 && rcnt <= ND - 2 && s1 >= 0;
      o_g0 = int'(go0); o_g1 = int'(go1); o_p0 = int'(go0_preg);
      o_rs0 = int'(go0_rs); o_rs1 = int'(go1_rs); o_rob0 = int'(go0_rob);
      chk("R3 slot0 grant", int'(go0), int'(e0));
      chk("R2 slot1 grant", int'(go1), int'(e1));
      if (e0) begin
         chk("R6 slot0 rename reg", int'(go0_preg), p0);
         chk("R5 slot0 station", int'(go0_rs), s0);
         chk("R7 slot0 rob entry", int'(go0_rob), rtail);
         pf[p0] = 1'b0;
         if (m0) mf[s0] = 1'b0; else af[s0] = 1'b0;
      end
      if (e1) begin
         chk("R6 slot1 rename reg", int'(go1_preg), p1);
         chk("R5 slot1 station", int'(go1_rs), s1);
         chk("R7 slot1 rob entry", int'(go1_rob), (rtail + 1) % ND);
         pf[p1] = 1'b0;
         if (m1) mf[s1] = 1'b0; else af[s1] = 1'b0;
      end
      if (pri >= 0) pf[pri] = 1'b1;
      if (ari >= 0) af[ari] = 1'b1;
      if (mri >= 0) mf[mri] = 1'b1;
      n = int'(e0) + int'(e1);
      rcnt = rcnt + n - rtc;
      rtail = (rtail + n) % ND;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1 (run completion)");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: first grant after reset
      cyc(1, 0, 1, 0, 0, 0, 0, 0);
      chk("R1 first rename reg", o_p0, 0);
      chk("R1 first station", o_rs0, 0);
      chk("R1 first rob entry", o_rob0, 0);
      chk("R6 slot1 next station", o_rs1, 1);
      // R4: one adder station left for two adds
      cyc(1, 0, 1, 0, 0, 0, 0, 0);
      chk("R4 slot0 goes", o_g0, 1);
      chk("R4 slot1 held", o_g1, 0);
      // R5: multiply routed to its own group while adders are exhausted
      cyc(1, 1, 1, 0, 0, 0, 0, 0);
      chk("R5 mul slot granted", o_g0, 1);
      chk("R5 mul station index", o_rs0, 0);
      chk("R5 add slot held", o_g1, 0);
      // R8: reclaim not usable in same cycle
      cyc(1, 0, 0, 0, 0, 1, 0, 0);
      chk("R8 same-cycle reclaim unused", o_g0, 0);
      cyc(1, 0, 0, 0, 0, 0, 0, 0);
      chk("R8 reclaim usable next cycle", o_g0, 1);
      chk("R8 reclaimed station", o_rs0, 0);

      // R9: fill reorder buffer while stations keep coming back
      do_reset();
      for (int k = 0; k < 4; k++) cyc(1, 0, 1, 1, 0, 1, 1, 0);
      cyc(1, 0, 1, 1, 0, 1, 1, 0);
      chk("R9 full buffer stalls", o_g0, 0);
      cyc(1, 0, 1, 1, 0, 0, 0, 1);
      chk("R9 retire not usable same cycle", o_g0, 0);
      cyc(1, 0, 1, 1, 0, 0, 0, 0);
      chk("R9 one slot after one retire", o_g0, 1);
      chk("R9 second slot held", o_g1, 0);
      cyc(1, 0, 1, 1, 0, 1, 1, 2);
      cyc(1, 1, 1, 0, 1, 1, 1, 0);
      chk("R9 two slots after two retires", o_g1, 1);

      // pseudo-random sweep over all slot, reclaim and retire mixes
      for (int k = 0; k < 6000; k++) begin
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         cyc(lfsr[0] | lfsr[10], lfsr[1], lfsr[2] | lfsr[11], lfsr[3],
             lfsr[4] | lfsr[5], lfsr[6], lfsr[7], int'(lfsr[9:8]));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule